// File: doc/BRIEF.md
# Priority Reference Switchover Controller

This block picks which of four clock references drives a downstream phase-locked loop. External monitors supply one valid flag per reference; the block itself only arbitrates. Each reference carries two programmable 2-bit priorities. The selection priority is used when a reference competes to become active. The promoted priority replaces it only while that reference is the active one. A smaller number is a higher priority. Because the active reference can hold a better promoted value, a newly recovered reference does not cause an unwanted switchover.

The block switches in three cases. It leaves holdover when any reference becomes valid. It fails over when the active reference loses its valid flag. It pre-empts when a valid reference has a selection priority strictly better than the active reference's promoted priority. On each switchover it emits a one-cycle strobe. Along with the strobe it gives a build-out flag, which tells the loop to absorb the phase step. The flag is raised unless the new reference is a phase master, meaning its selection priority is strictly below a programmable threshold. The threshold clears to 0 on reset, so by default no reference is a phase master.

Top module: `refsw_ctrl`

## Requirements
- R1: After reset the block is in holdover with active_idx 0, holdover 1, switch_pulse 0 and buildout 0. The threshold register reads as 0.
- R2: In holdover, the first cycle with any valid reference selects the valid reference with the lowest selection priority value. A tie goes to the lowest index (0 = A, 1 = AA, 2 = B, 3 = BB). Priority i sits in bits [2i+1:2i] of its bus.
- R3: While the active reference is valid, its promoted priority is its effective priority. Another valid reference takes over only if its selection priority is strictly lower than that promoted value.
- R4: A valid reference whose selection priority equals the active reference's effective priority causes no switchover.
- R5: When the active reference loses its valid flag and another reference is valid, the block switches to the best valid reference by selection priority, with the lowest index winning a tie.
- R6: When no reference is valid, holdover is 1, switch_pulse stays 0 and active_idx keeps its last value.
- R7: switch_pulse is high for exactly the one cycle after each decision to switch. Each registered output appears one clock after the inputs that cause it. active_idx changes only together with switch_pulse.
- R8: buildout is high only together with switch_pulse. It is 1 when the new reference's selection priority is greater than or equal to the threshold, and 0 when the new reference is a phase master.
- R9: A pulse on thr_load stores thr_value as the threshold. The new threshold applies to decisions from the following clock onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_valid | input | 4 | Per-reference valid flags from the monitors |
| sel_prio | input | 8 | Selection priorities, 2 bits per reference |
| promo_prio | input | 8 | Promoted priorities, 2 bits per reference |
| thr_load | input | 1 | Load strobe for the phase-master threshold |
| thr_value | input | 2 | Threshold value to load |
| active_idx | output | 2 | Index of the active reference |
| holdover | output | 1 | No reference is active |
| switch_pulse | output | 1 | One-cycle switchover strobe |
| buildout | output | 1 | Phase build-out request for this switchover |

## Verification
A directed sequence first replays the pairwise scenario. Two references share selection priority 3 and promoted priority 1; they become active when the priority-2 pair is invalid and then keep the role when that pair recovers. This tells promoted-priority suppression apart from a plain selection-priority comparison. The sequence then drives an equal-priority tie, a fault of the active reference, a threshold load and an all-invalid cycle. These separate strict comparison, failover search, phase-master gating and holdover retention. Seeded random valid patterns, priority rewrites and threshold loads then run against a bench model. These cover combinations of simultaneous faults, recoveries and ties that the directed cases do not reach.

// File: rtl/refsw_pkg.sv
package refsw_pkg;

  typedef enum logic [1:0] {
    EV_NONE     = 2'd0,
    EV_ACQUIRE  = 2'd1,
    EV_FAILOVER = 2'd2,
    EV_PREEMPT  = 2'd3
  } refsw_ev_e;

endpackage

// File: rtl/refsw_arbiter.sv
module refsw_arbiter #(
  parameter int NUM_REF = 4,
  parameter int PRIO_W  = 2,
  localparam int IDX_W  = (NUM_REF > 1) ? $clog2(NUM_REF) : 1
) (
  input  logic [NUM_REF-1:0]        elig,
  input  logic [NUM_REF*PRIO_W-1:0] prio,
  output logic                      found,
  output logic [IDX_W-1:0]          best_idx,
  output logic [PRIO_W-1:0]         best_prio
);

  logic              hit   [NUM_REF+1];
  logic [IDX_W-1:0]  idx_c [NUM_REF+1];
  logic [PRIO_W-1:0] pr_c  [NUM_REF+1];

  assign hit[0]   = 1'b0;
  assign idx_c[0] = '0;
  assign pr_c[0]  = '0;

  // Linear chain: a later entry wins only with a strictly smaller value,
  // so ties keep the lower index.
  for (genvar i = 0; i < NUM_REF; i++) begin : g_stage
    logic take;
    assign take = elig[i] &&
                  (!hit[i] || (prio[i*PRIO_W +: PRIO_W] < pr_c[i]));
    assign hit[i+1]   = hit[i] | elig[i];
    assign idx_c[i+1] = take ? IDX_W'(i) : idx_c[i];
    assign pr_c[i+1]  = take ? prio[i*PRIO_W +: PRIO_W] : pr_c[i];
  end

  assign found     = hit[NUM_REF];
  assign best_idx  = idx_c[NUM_REF];
  assign best_prio = pr_c[NUM_REF];

endmodule

// File: rtl/refsw_thresh.sv
module refsw_thresh #(
  parameter int PRIO_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PRIO_W-1:0] din,
  output logic [PRIO_W-1:0] thr_q
);

  logic [PRIO_W-1:0] thr_d;

  always_comb begin
    thr_d = thr_q;
    if (load) thr_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_q <= '0;
    else        thr_q <= thr_d;
  end

endmodule

// File: rtl/refsw_decide.sv
module refsw_decide
  import refsw_pkg::*;
#(
  parameter int PRIO_W = 2
) (
  input  logic              act_vld,
  input  logic              act_ok,
  input  logic [PRIO_W-1:0] eff_prio,
  input  logic              cand_found,
  input  logic [PRIO_W-1:0] cand_prio,
  output logic              take,
  output refsw_ev_e         ev
);

  always_comb begin
    if (act_ok) take = cand_found && (cand_prio < eff_prio);
    else        take = cand_found;

    if (!take)         ev = EV_NONE;
    else if (!act_vld) ev = EV_ACQUIRE;
    else if (!act_ok)  ev = EV_FAILOVER;
    else               ev = EV_PREEMPT;
  end

endmodule

// File: rtl/refsw_ctrl.sv
module refsw_ctrl
  import refsw_pkg::*;
#(
  parameter int NUM_REF = 4,
  parameter int PRIO_W  = 2,
  localparam int IDX_W  = (NUM_REF > 1) ? $clog2(NUM_REF) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_REF-1:0]        ref_valid,
  input  logic [NUM_REF*PRIO_W-1:0] sel_prio,
  input  logic [NUM_REF*PRIO_W-1:0] promo_prio,
  input  logic                      thr_load,
  input  logic [PRIO_W-1:0]         thr_value,
  output logic [IDX_W-1:0]          active_idx,
  output logic                      holdover,
  output logic                      switch_pulse,
  output logic                      buildout
);

  logic [IDX_W-1:0]   idx_q, idx_d;
  logic               vld_q, vld_d;
  logic               pulse_q, pulse_d;
  logic               bo_q, bo_d;
  logic [PRIO_W-1:0]  thr_q;

  logic               act_ok;
  logic [PRIO_W-1:0]  eff_prio;
  logic [NUM_REF-1:0] act_mask;
  logic [NUM_REF-1:0] elig;
  logic               cand_found;
  logic [IDX_W-1:0]   cand_idx;
  logic [PRIO_W-1:0]  cand_prio;
  logic               take;
  refsw_ev_e          ev;

  refsw_thresh #(.PRIO_W(PRIO_W)) u_thr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (thr_load),
    .din   (thr_value),
    .thr_q (thr_q)
  );

  for (genvar i = 0; i < NUM_REF; i++) begin : g_mask
    assign act_mask[i] = vld_q && (idx_q == IDX_W'(i));
  end

  assign act_ok   = |(act_mask & ref_valid);
  assign eff_prio = promo_prio[idx_q*PRIO_W +: PRIO_W];
  assign elig     = ref_valid & ~act_mask;

  refsw_arbiter #(.NUM_REF(NUM_REF), .PRIO_W(PRIO_W)) u_arb (
    .elig      (elig),
    .prio      (sel_prio),
    .found     (cand_found),
    .best_idx  (cand_idx),
    .best_prio (cand_prio)
  );

  refsw_decide #(.PRIO_W(PRIO_W)) u_dec (
    .act_vld    (vld_q),
    .act_ok     (act_ok),
    .eff_prio   (eff_prio),
    .cand_found (cand_found),
    .cand_prio  (cand_prio),
    .take       (take),
    .ev         (ev)
  );

  always_comb begin
    idx_d   = idx_q;
    vld_d   = act_ok;
    pulse_d = 1'b0;
    bo_d    = 1'b0;
    if (ev != EV_NONE) begin
      idx_d   = cand_idx;
      vld_d   = 1'b1;
      pulse_d = 1'b1;
      bo_d    = !(cand_prio < thr_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      vld_q   <= 1'b0;
      pulse_q <= 1'b0;
      bo_q    <= 1'b0;
    end else begin
      idx_q   <= idx_d;
      vld_q   <= vld_d;
      pulse_q <= pulse_d;
      bo_q    <= bo_d;
    end
  end

  assign active_idx   = idx_q;
  assign holdover     = !vld_q;
  assign switch_pulse = pulse_q;
  assign buildout     = bo_q;

endmodule

// File: rtl/refsw_ctrl_chk.sv
module refsw_ctrl_chk #(
  parameter int NUM_REF = 4,
  parameter int IDX_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_REF-1:0] ref_valid,
  input logic [IDX_W-1:0]   active_idx,
  input logic               holdover,
  input logic               switch_pulse,
  input logic               buildout
);

  logic [NUM_REF-1:0] valid_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_d <= '0;
    else        valid_d <= ref_valid;
  end

  // R8: build-out only accompanies a switchover
  p_bo_with_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    buildout |-> switch_pulse);

  // R7: index moves only with the strobe
  p_idx_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !switch_pulse |-> $stable(active_idx));

  // R6: nothing valid in the previous cycle means holdover and no strobe
  p_hold_when_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_d == '0) |-> (holdover && !switch_pulse));

  // R2: a switchover always lands on a reference that was valid
  p_target_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    switch_pulse |-> (valid_d[active_idx] && !holdover));

endmodule

bind refsw_ctrl refsw_ctrl_chk #(.NUM_REF(NUM_REF), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ref_valid    (ref_valid),
  .active_idx   (active_idx),
  .holdover     (holdover),
  .switch_pulse (switch_pulse),
  .buildout     (buildout)
);

// File: tb/tb_refsw_ctrl.sv
`timescale 1ns/1ps
module tb_refsw_ctrl;

  logic       clk;
  logic       rst_n;
  logic [3:0] ref_valid;
  logic [7:0] sel_prio;
  logic [7:0] promo_prio;
  logic       thr_load;
  logic [1:0] thr_value;
  logic [1:0] active_idx;
  logic       holdover;
  logic       switch_pulse;
  logic       buildout;

  int nchk = 0;
  int nerr = 0;

  int m_idx = 0;
  bit m_act = 0;
  int m_thr = 0;
  int e_idx = 0;
  bit e_hold = 1, e_pulse = 0, e_bo = 0;

  refsw_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid),
    .sel_prio(sel_prio), .promo_prio(promo_prio),
    .thr_load(thr_load), .thr_value(thr_value),
    .active_idx(active_idx), .holdover(holdover),
    .switch_pulse(switch_pulse), .buildout(buildout)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(string tag, int act, int exp, string what);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int sp(int i);
    return int'(sel_prio[2*i +: 2]);
  endfunction

  function automatic int pp(int i);
    return int'(promo_prio[2*i +: 2]);
  endfunction

  // Apply current inputs for one clock and compare with the model.
  task automatic step();
    bit act_ok;
    bit found;
    int best;
    bit sw;
    act_ok = m_act && ref_valid[m_idx];
    found  = 0;
    best   = 0;
    for (int i = 0; i < 4; i++) begin
      if (ref_valid[i] && !(m_act && i == m_idx)) begin
        if (!found || sp(i) < sp(best)) begin
          best  = i;
          found = 1;
        end
      end
    end
    sw = act_ok ? (found && sp(best) < pp(m_idx)) : found;
    if (sw) begin
      m_idx = best; m_act = 1; e_pulse = 1; e_bo = (sp(best) >= m_thr);
    end else begin
      m_act = act_ok; e_pulse = 0; e_bo = 0;
    end
    e_idx = m_idx; e_hold = !m_act;
    if (thr_load) m_thr = int'(thr_value);
    @(posedge clk);
    @(negedge clk);
    chk("R3", int'(active_idx), e_idx, "active_idx");
    chk("R6", int'(holdover), int'(e_hold), "holdover");
    chk("R7", int'(switch_pulse), int'(e_pulse), "switch_pulse");
    chk("R8", int'(buildout), int'(e_bo), "buildout");
    thr_load = 1'b0;
  endtask

  initial begin
    #1_000_000;
    nerr++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd5417));
    rst_n = 0; ref_valid = 0; thr_load = 0; thr_value = 0;
    // A=2 AA=2 B=3 BB=3 ; promoted A=2 AA=2 B=1 BB=1
    sel_prio   = {2'd3, 2'd3, 2'd2, 2'd2};
    promo_prio = {2'd1, 2'd1, 2'd2, 2'd2};
    repeat (4) @(negedge clk);
    rst_n = 1;
    chk("R1", int'(active_idx), 0, "reset idx");
    chk("R1", int'(holdover), 1, "reset holdover");
    chk("R1", int'(switch_pulse), 0, "reset pulse");
    chk("R1", int'(buildout), 0, "reset buildout");

    step();
    chk("R6", int'(holdover), 1, "none valid");
    ref_valid = 4'b1100; step();
    chk("R2", int'(active_idx), 2, "tie picks B");
    chk("R2", int'(switch_pulse), 1, "acquire pulse");
    chk("R9", int'(buildout), 1, "threshold 0 gives buildout");
    step();
    chk("R7", int'(switch_pulse), 0, "pulse one cycle");
    ref_valid = 4'b1111; step();
    chk("R3", int'(switch_pulse), 0, "promoted holds B");
    chk("R3", int'(active_idx), 2, "stay on B");
    ref_valid = 4'b1011; step();
    chk("R5", int'(active_idx), 0, "failover to A");
    chk("R5", int'(switch_pulse), 1, "failover pulse");
    ref_valid = 4'b1011; step();
    chk("R4", int'(switch_pulse), 0, "AA ties with A");
    thr_load = 1; thr_value = 2'd3; step();
    ref_valid = 4'b1010; step();
    chk("R9", int'(active_idx), 1, "failover to AA");
    chk("R8", int'(buildout), 0, "phase master no buildout");
    ref_valid = 4'b0000; step();
    chk("R6", int'(holdover), 1, "holdover entered");
    chk("R6", int'(active_idx), 1, "index kept");
    chk("R6", int'(switch_pulse), 0, "no pulse in holdover");

    for (int n = 0; n < 4000; n++) begin
      logic [3:0] v;
      for (int i = 0; i < 4; i++) v[i] = (($urandom % 4) != 0);
      if (($urandom % 10) == 0) v = 4'b0000;
      ref_valid = v;
      if (($urandom % 16) == 0) begin
        sel_prio   = 8'($urandom);
        promo_prio = 8'($urandom);
      end
      if (($urandom % 32) == 0) begin
        thr_load  = 1'b1;
        thr_value = 2'($urandom);
      end
      step();
    end

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule